// File: doc/BRIEF.md
# Dual-Modulus Fractional Clock Divider

This block divides one input clock by a ratio that need not be an integer. It switches between two integer divide ratios. Each ratio is held for its own programmed number of output periods, so over a full sequence the average output frequency falls between the two integer ratios. The usual job is to derive a precise low-rate clock, for example an average 32.768 kHz, from a much faster reference by mixing ratios that differ by one.

Each programmed field holds the wanted value minus one. A mode input selects single operation, which uses only the first divider, or dual operation, which alternates the two. The output is a square-wave enable that starts high in each period. A one-cycle strobe marks the first cycle of every period, and a select flag shows which divider is running. New field values take effect only on a sequence boundary, so a period is never cut short.

Top module: `fracdiv_top`

## Requirements
- R1: With `dual_mode` = 0 at a sequence start, every output period lasts `div_a_fld`+1 input cycles, `active_sel` stays 0, and `rep_a_fld`, `div_b_fld` and `rep_b_fld` have no effect on any output.
- R2: With `dual_mode` = 1, the block produces `rep_a_fld`+1 periods of `div_a_fld`+1 cycles with `active_sel` = 0. It then produces `rep_b_fld`+1 periods of `div_b_fld`+1 cycles with `active_sel` = 1, and repeats this pattern forever.
- R3: Over one complete dual sequence the block emits exactly M1+M2 strobes in N1·M1+N2·M2 input cycles, where N and M are the field values plus one.
- R4: A field value of 0 means a count of 1. A divide of 1 keeps `clk_out` and `period_start` high on every cycle of that period.
- R5: The inputs are sampled on the clock edge that starts a sequence. A sequence is one period in single mode and one full dual pattern in dual mode. Changes made at any other time do not alter the sequence in progress.
- R6: Within a period of N cycles, `clk_out` is high for the first max(1, floor(N/2)) cycles and low for the rest.
- R7: `period_start` is high only in the first cycle of each period, and `clk_out` is high in that cycle.
- R8: After a clock edge that samples `rst` = 1 or `en` = 0, all three outputs are 0. The first period begins in the cycle after the first edge that samples `en` = 1, using the inputs sampled on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input reference clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the block at the start of divider one |
| dual_mode | input | 1 | 0 = single divider, 1 = alternate two dividers |
| div_a_fld | input | W | First divide ratio minus one |
| rep_a_fld | input | W | Period count for the first ratio minus one |
| div_b_fld | input | W | Second divide ratio minus one |
| rep_b_fld | input | W | Period count for the second ratio minus one |
| clk_out | output | 1 | Divided square-wave enable |
| period_start | output | 1 | One-cycle strobe on the first cycle of each period |
| active_sel | output | 1 | 0 while the first ratio runs, 1 while the second runs |

## Verification
A wrong cycle counter shows up as a strobe spacing that differs from the expected length within one period. A wrong repeat counter or select register shows up as `active_sel` toggling on the wrong strobe within one sequence. A latched configuration taken at the wrong moment shows up as period lengths that follow the new fields before the sequence boundary. The reference model predicts every output on every cycle, so any such error is flagged in the cycle where it first reaches a port, and whole-sequence cycle and strobe totals confirm the average ratio.

// File: rtl/fracdiv_pkg.sv
package fracdiv_pkg;

    localparam int FD_FIELD_W = 12;

    typedef enum logic {
        DIV_FIRST  = 1'b0,
        DIV_SECOND = 1'b1
    } div_sel_e;

    // True when the period now ending closes a whole sequence
    function automatic logic seq_closes(input logic dual, input div_sel_e sel);
        return !dual || (sel == DIV_SECOND);
    endfunction

endpackage

// File: rtl/fd_period_ctr.sv
module fd_period_ctr #(
    parameter int W = fracdiv_pkg::FD_FIELD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         go,
    input  logic [W-1:0] len_m1,
    output logic [W-1:0] cyc,
    output logic         wrap
);
    logic at_last;

    assign at_last = (cyc == len_m1);
    assign wrap    = go && at_last;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cyc <= '0;
        end else if (go) begin
            cyc <= at_last ? '0 : cyc + 1'b1;
        end
    end
endmodule

// File: rtl/fd_phase_seq.sv
module fd_phase_seq
    import fracdiv_pkg::*;
#(
    parameter int W = FD_FIELD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         run,
    input  logic         wrap,
    input  logic         dual_i,
    input  logic [W-1:0] div_a_i,
    input  logic [W-1:0] rep_a_i,
    input  logic [W-1:0] div_b_i,
    input  logic [W-1:0] rep_b_i,
    output div_sel_e     sel,
    output logic         dual_o,
    output logic [W-1:0] len_m1
);
    localparam int CFG_W = 4 * W + 1;

    logic [CFG_W-1:0] cfg_q;
    logic [CFG_W-1:0] cfg_in;
    logic [W-1:0]     div_a_q, rep_a_q, div_b_q, rep_b_q;
    logic [W-1:0]     rep_q;
    logic             rep_last;

    assign cfg_in = {dual_i, div_a_i, rep_a_i, div_b_i, rep_b_i};
    assign {dual_o, div_a_q, rep_a_q, div_b_q, rep_b_q} = cfg_q;

    assign len_m1   = (sel == DIV_SECOND) ? div_b_q : div_a_q;
    assign rep_last = (rep_q == ((sel == DIV_SECOND) ? rep_b_q : rep_a_q));

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cfg_q <= cfg_in;
            sel   <= DIV_FIRST;
            rep_q <= '0;
        end else if (!run) begin
            cfg_q <= cfg_in;
        end else if (wrap) begin
            if (!dual_o) begin
                cfg_q <= cfg_in;
            end else if (rep_last) begin
                rep_q <= '0;
                if (seq_closes(dual_o, sel)) begin
                    sel   <= DIV_FIRST;
                    cfg_q <= cfg_in;
                end else begin
                    sel <= DIV_SECOND;
                end
            end else begin
                rep_q <= rep_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/fracdiv_top.sv
module fracdiv_top
    import fracdiv_pkg::*;
#(
    parameter int W = FD_FIELD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         dual_mode,
    input  logic [W-1:0] div_a_fld,
    input  logic [W-1:0] rep_a_fld,
    input  logic [W-1:0] div_b_fld,
    input  logic [W-1:0] rep_b_fld,
    output logic         clk_out,
    output logic         period_start,
    output logic         active_sel
);
    logic         run_q;
    logic         go;
    logic         per_wrap;
    logic         cfg_dual;
    logic [W-1:0] cyc;
    logic [W-1:0] len_m1;
    logic [W:0]   len;
    logic [W:0]   hi_len;
    div_sel_e     sel;

    always_ff @(posedge clk) begin
        if (rst) run_q <= 1'b0;
        else     run_q <= en;
    end

    assign go = run_q && en;

    fd_period_ctr #(.W(W)) u_ctr (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .go     (go),
        .len_m1 (len_m1),
        .cyc    (cyc),
        .wrap   (per_wrap)
    );

    fd_phase_seq #(.W(W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .run     (run_q),
        .wrap    (per_wrap),
        .dual_i  (dual_mode),
        .div_a_i (div_a_fld),
        .rep_a_i (rep_a_fld),
        .div_b_i (div_b_fld),
        .rep_b_i (rep_b_fld),
        .sel     (sel),
        .dual_o  (cfg_dual),
        .len_m1  (len_m1)
    );

    assign len    = {1'b0, len_m1} + 1'b1;
    assign hi_len = (len_m1 == '0) ? {{W{1'b0}}, 1'b1} : (len >> 1);

    assign clk_out      = run_q && ({1'b0, cyc} < hi_len);
    assign period_start = run_q && (cyc == '0);
    assign active_sel   = run_q && (sel == DIV_SECOND);
endmodule

// File: rtl/fd_checker.sv
module fd_checker (
    input logic clk,
    input logic rst,
    input logic en,
    input logic run_q,
    input logic cfg_dual,
    input logic per_wrap,
    input logic clk_out,
    input logic period_start,
    input logic active_sel
);
    // R7
    strobe_high_chk: assert property (@(posedge clk) disable iff (rst)
        period_start |-> clk_out);

    // R7
    wrap_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        per_wrap |=> period_start);

    // R6
    rise_at_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(clk_out) |-> period_start);

    // R8
    off_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!clk_out && !period_start && !active_sel));

    // R8
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (!clk_out && !period_start && !active_sel));

    // R2
    sel_switch_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && $past(run_q) && (active_sel != $past(active_sel))) |-> period_start);

    // R1
    single_first_chk: assert property (@(posedge clk) disable iff (rst)
        (run_q && !cfg_dual) |-> !active_sel);
endmodule

bind fracdiv_top fd_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .en           (en),
    .run_q        (run_q),
    .cfg_dual     (cfg_dual),
    .per_wrap     (per_wrap),
    .clk_out      (clk_out),
    .period_start (period_start),
    .active_sel   (active_sel)
);

// File: tb/tb_fracdiv_top.sv
module tb_fracdiv_top;
    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en  = 1'b0;
    logic         dual_mode = 1'b0;
    logic [W-1:0] div_a_fld = '0, rep_a_fld = '0, div_b_fld = '0, rep_b_fld = '0;
    logic         clk_out, period_start, active_sel;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    fracdiv_top #(.W(W)) dut (
        .clk(clk), .rst(rst), .en(en), .dual_mode(dual_mode),
        .div_a_fld(div_a_fld), .rep_a_fld(rep_a_fld),
        .div_b_fld(div_b_fld), .rep_b_fld(rep_b_fld),
        .clk_out(clk_out), .period_start(period_start), .active_sel(active_sel)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: a queue of upcoming periods (length, selector)
    int q_len[$];
    bit q_sel[$];
    int cur_len = 1;
    bit cur_sel = 0;
    int pos = 0;
    bit run = 0;

    task automatic build_seq();
        if (!dual_mode) begin
            q_len.push_back(int'(div_a_fld) + 1); q_sel.push_back(1'b0);
        end else begin
            for (int i = 0; i <= int'(rep_a_fld); i++) begin
                q_len.push_back(int'(div_a_fld) + 1); q_sel.push_back(1'b0);
            end
            for (int i = 0; i <= int'(rep_b_fld); i++) begin
                q_len.push_back(int'(div_b_fld) + 1); q_sel.push_back(1'b1);
            end
        end
    endtask

    task automatic next_period();
        if (q_len.size() == 0) build_seq();
        cur_len = q_len.pop_front();
        cur_sel = q_sel.pop_front();
        pos = 0;
    endtask

    always @(posedge clk) begin
        if (rst || !en) begin
            run = 0; pos = 0;
            q_len.delete(); q_sel.delete();
        end else if (!run) begin
            run = 1;
            next_period();
        end else begin
            pos++;
            if (pos == cur_len) next_period();
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        int hi;
        hi = (cur_len == 1) ? 1 : cur_len / 2;
        if (!done) begin
            chk("R6 clk_out", int'(clk_out), int'(run && pos < hi));
            chk("R7 period_start", int'(period_start), int'(run && pos == 0));
            chk("R2 active_sel", int'(active_sel), int'(run && cur_sel));
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic restart();
        step(1); en = 1'b0;
        step(1); en = 1'b1;
        do @(negedge clk); while (!period_start);
    endtask

    // Counts from the current negedge (a sequence start) to the next one
    task automatic measure_seq(output int cyc, output int strobes);
        bit seen_second;
        cyc = 0; strobes = 0; seen_second = 0;
        do begin
            if (period_start) strobes++;
            if (active_sel) seen_second = 1;
            cyc++;
            @(negedge clk);
        end while (!(period_start && !active_sel && seen_second));
    endtask

    task automatic period_len(output int n);
        n = 0;
        do begin n++; @(negedge clk); end while (!period_start);
    endtask

    initial begin
        int c, s, n;
        step(3);
        @(negedge clk);
        // R8 reset state
        chk("R8 reset clk_out", int'(clk_out), 0);
        chk("R8 reset period_start", int'(period_start), 0);
        chk("R8 reset active_sel", int'(active_sel), 0);

        // R1 single mode, other fields set to unrelated values
        step(1);
        rst = 1'b0; dual_mode = 1'b0;
        div_a_fld = 3; rep_a_fld = 7; div_b_fld = 9; rep_b_fld = 5;
        en = 1'b1;
        do @(negedge clk); while (!period_start);
        period_len(n);
        chk("R1 single period", n, 4);
        step(2); div_b_fld = 1; rep_b_fld = 0; rep_a_fld = 2;
        step(20);
        do @(negedge clk); while (!period_start);
        period_len(n);
        chk("R1 ignored fields period", n, 4);
        chk("R1 active_sel", int'(active_sel), 0);

        // R8 enable low
        step(1); en = 1'b0;
        step(1);
        @(negedge clk);
        chk("R8 disabled clk_out", int'(clk_out), 0);
        chk("R8 disabled period_start", int'(period_start), 0);

        // R4 divide of one
        div_a_fld = 0; en = 1'b1;
        step(3);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk("R4 N1 clk_out", int'(clk_out), 1);
            chk("R4 N1 strobe", int'(period_start), 1);
        end

        // R2 dual: N1=3 M1=2 N2=4 M2=1
        step(1);
        dual_mode = 1'b1; div_a_fld = 2; rep_a_fld = 1; div_b_fld = 3; rep_b_fld = 0;
        restart();
        measure_seq(c, s);
        chk("R2 dual cycles", c, 10);
        chk("R2 dual strobes", s, 3);
        step(30);

        // R3 average ratio: N1=5 M1=3 N2=6 M2=2
        div_a_fld = 4; rep_a_fld = 2; div_b_fld = 5; rep_b_fld = 1;
        restart();
        measure_seq(c, s);
        chk("R3 seq cycles", c, 27);
        chk("R3 seq strobes", s, 5);

        // R5 mid-sequence change has no effect until the boundary
        restart();
        fork
            measure_seq(c, s);
            begin step(3); div_a_fld = 0; rep_a_fld = 0; end
        join
        chk("R5 old seq cycles", c, 27);
        chk("R5 old seq strobes", s, 5);
        measure_seq(c, s);
        chk("R5 new seq cycles", c, 13);
        chk("R5 new seq strobes", s, 3);

        // R8 reset mid-run, then restart
        step(2); rst = 1'b1;
        step(1); rst = 1'b0;
        @(negedge clk);
        chk("R8 mid reset clk_out", int'(clk_out), 0);
        chk("R8 mid reset active_sel", int'(active_sel), 0);

        // R4 mixed: N1=1 M1=3, N2=2 M2=2
        div_a_fld = 0; rep_a_fld = 2; div_b_fld = 1; rep_b_fld = 1;
        restart();
        measure_seq(c, s);
        chk("R4 mixed cycles", c, 7);
        chk("R4 mixed strobes", s, 5);

        // Single repeats: N1=6 M1=1, N2=7 M2=1
        div_a_fld = 5; rep_a_fld = 0; div_b_fld = 6; rep_b_fld = 0;
        restart();
        measure_seq(c, s);
        chk("R3 unit repeat cycles", c, 13);
        chk("R3 unit repeat strobes", s, 2);
        step(40);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule